// File: doc/BRIEF.md
# Inverted-Pyramid Wallace Multiplier

This block is a purely combinational unsigned multiplier for two N-bit operands (N defaults to 8). It forms every AND term of the two operands. It then packs the bits of each weight column toward the top of that column, so the partial-product matrix takes the shape of an inverted pyramid. The matrix is then compressed over a fixed number of reduction levels. At each level every column is cut into groups of three stacked bits, and each complete group goes through a full adder. A pair of bits left over at the bottom of a column is normally passed on unchanged. It is merged by a half adder only when passing it would leave that column taller than the level allows. The level count is that of a conventional Wallace tree for N rows. A single leftover bit is passed on without logic. When two rows are left, a ripple carry-propagate adder produces the 2N-bit product.

The block is meant to sit inside a datapath as a drop-in multiplier. It has no clock and no state. The compression schedule (adders per column and level) is computed at elaboration from N alone. For the chosen width the block reports its number of reduction levels as a constant output.

Top module: `pyramid_wallace_mul`

## Requirements
- R1: `product_o` equals the exact unsigned product `a_i * b_i` for every pair of N-bit operands.
- R2: `depth_o` reports the number of reduction levels, and it equals the conventional Wallace level count for N rows: the smallest k for which the sequence 2, 3, 4, 6, 9, 13, … (each term is floor(3/2) of the previous one) reaches at least N at index k. The count is 4 for N = 8 and 3 for N = 5.
- R3: Every reduction level keeps the weighted value of the bit matrix unchanged, modulo 2^(2N), for all-ones, alternating and random-looking operands.
- R4: A zero operand gives a zero product, and this includes both operands being zero.
- R5: The largest operands (2^N − 1 on both inputs) give (2^N − 1)^2, with bit 2N−1 set and no carry lost at the most significant column.
- R6: An operand that is a power of two, 2^k, gives the other operand shifted left by k positions.
- R7: The final carry-propagate adder returns the exact sum of the two remaining rows, including patterns that ripple a carry across the full 2N-bit width.
- R8: The product is also exact for an odd operand width (N = 5), where the pyramid has an odd number of columns of full height.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| product_o | output | 2N | Unsigned product |
| depth_o | output | 8 | Number of reduction levels used for this N (constant) |

## Verification
The bench builds two copies of the block, one with N = 8 and one with N = 5. Both widths are small enough for an exhaustive sweep: 65,536 operand pairs for N = 8 and 1,024 for N = 5. That covers every zero, power-of-two, maximum and carry-rippling case. The odd width reaches a pyramid with a different column profile and a different level count (3 instead of 4). This exercises both the half-adder placement rule and the compacted-slot indexing under a second schedule.

// File: rtl/pyr_wallace_pkg.sv
`timescale 1ns/1ps
// Package: compression schedule for the inverted-pyramid Wallace multiplier.
// Assumes N <= 64. All functions are constant functions and are evaluated at
// elaboration only.
package pyr_wallace_pkg;

    localparam int MAX_COLS  = 128;
    localparam int MAX_LEVEL = 16;

    localparam int QRY_HEIGHT = 0;
    localparam int QRY_FA     = 1;
    localparam int QRY_HA     = 2;
    localparam int QRY_LEVELS = 3;

    // Conventional Wallace level count for a matrix of 'rows' rows.
    function automatic int wallace_levels(input int rows);
        int cap;
        int k;
        cap = 2;
        k   = 0;
        while (cap < rows) begin
            cap = (3 * cap) / 2;
            k   = k + 1;
        end
        return k;
    endfunction

    // Largest column height that can still be finished in 'left' levels.
    function automatic int height_cap(input int left);
        int cap;
        cap = 2;
        for (int i = 0; i < left; i++) begin
            cap = (3 * cap) / 2;
        end
        return cap;
    endfunction

    // Runs the whole schedule for width n and returns one quantity:
    // column height entering level lvl, full adders or half adders used in
    // column col at level lvl, or the number of levels needed in total.
    function automatic int plan_query(input int n, input int qry,
                                      input int lvl, input int col);
        int h  [MAX_COLS];
        int nh [MAX_COLS];
        int fa [MAX_COLS];
        int ha [MAX_COLS];
        int cols;
        int total;
        int target;
        int tallest;
        int rem;
        int cin;
        cols  = 2 * n;
        total = wallace_levels(n);
        for (int c = 0; c < MAX_COLS; c++) begin
            h[c]  = 0;
            nh[c] = 0;
            fa[c] = 0;
            ha[c] = 0;
        end
        for (int c = 0; c < cols - 1; c++) begin
            h[c] = ((c + 1) < (cols - 1 - c)) ? (c + 1) : (cols - 1 - c);
        end
        for (int s = 0; s < MAX_LEVEL; s++) begin
            if (qry == QRY_HEIGHT && s == lvl) return h[col];
            tallest = 0;
            for (int c = 0; c < cols; c++) begin
                if (h[c] > tallest) tallest = h[c];
            end
            if (tallest <= 2) begin
                if (qry == QRY_LEVELS) return s;
                return 0;
            end
            target = (total - s - 1 >= 0) ? height_cap(total - s - 1) : 2;
            for (int c = 0; c < cols; c++) begin
                cin   = (c > 0) ? (fa[c-1] + ha[c-1]) : 0;
                fa[c] = h[c] / 3;
                rem   = h[c] % 3;
                ha[c] = 0;
                if (rem == 2 && (fa[c] + 2 + cin) > target) ha[c] = 1;
                nh[c] = fa[c] + ((ha[c] == 1) ? 1 : rem) + cin;
            end
            if (qry == QRY_FA && s == lvl) return fa[col];
            if (qry == QRY_HA && s == lvl) return ha[col];
            for (int c = 0; c < cols; c++) begin
                h[c] = nh[c];
            end
        end
        return MAX_LEVEL;
    endfunction

endpackage

// File: rtl/csa_full.sv
`timescale 1ns/1ps
// Module: one-bit full adder (3:2 counter) used by the reduction levels and by
// the final ripple adder. Assumes nothing beyond single-bit inputs.
module csa_full (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);

    // Sum bit and carry bit of three equally weighted inputs.
    always_comb begin
        s  = x ^ y ^ z;
        co = (x & y) | (z & (x ^ y));
    end

endmodule

// File: rtl/pp_pyramid.sv
`timescale 1ns/1ps
// Module: forms the N x N AND terms and stores them column by column, with each
// column packed into slots 0..height-1 (the inverted pyramid). Slot k of
// column c holds a[i] & b[c-i] with i = max(0, c-N+1) + k. Unused slots are 0.
module pp_pyramid #(
    parameter int N = 8
) (
    input  logic [N-1:0]              a_i,
    input  logic [N-1:0]              b_i,
    output logic [2*N-1:0][N-1:0]     mat_o
);

    localparam int COLS = 2 * N;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int CNT  = (c >= COLS - 1) ? 0 :
                              (((c + 1) < (COLS - 1 - c)) ? (c + 1) : (COLS - 1 - c));
        localparam int IMIN = (c > N - 1) ? (c - N + 1) : 0;
        for (genvar k = 0; k < N; k++) begin : g_slot
            if (k < CNT) begin : g_term
                // AND term lifted to the top of its column.
                assign mat_o[c][k] = a_i[IMIN + k] & b_i[c - IMIN - k];
            end else begin : g_empty
                assign mat_o[c][k] = 1'b0;
            end
        end
    end

    logic [COLS-1:0] mat_val;
    logic [COLS-1:0] ref_val;

    // Weighted value of the packed matrix versus the arithmetic product.
    always_comb begin
        mat_val = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int k = 0; k < N; k++) begin
                mat_val = mat_val + (COLS'(mat_o[c][k]) << c);
            end
        end
        ref_val = COLS'(a_i) * COLS'(b_i);
        // R1
        pyramid_value_chk: assert (mat_val == ref_val)
            else $error("pyramid value %0d differs from product %0d", mat_val, ref_val);
    end

endmodule

// File: rtl/wallace_stage.sv
`timescale 1ns/1ps
// Module: one reduction level. In each column, complete groups of three slots
// go through full adders; a bottom pair is merged by a half adder only when the
// schedule requires it; other leftovers pass through. The output column is
// packed as: sums, passed bits, then carries arriving from the column below.
// Assumes the input matches the schedule height for level LVL.
module wallace_stage #(
    parameter int N   = 8,
    parameter int LVL = 0
) (
    input  logic [2*N-1:0][N-1:0] in_mat,
    output logic [2*N-1:0][N-1:0] out_mat
);

    import pyr_wallace_pkg::*;

    localparam int COLS = 2 * N;

    logic [COLS-1:0][N-1:0] sm;
    logic [COLS-1:0][N-1:0] cy;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int H    = plan_query(N, QRY_HEIGHT, LVL, c);
        localparam int FAN  = plan_query(N, QRY_FA, LVL, c);
        localparam int HAN  = plan_query(N, QRY_HA, LVL, c);
        localparam int PASS = (HAN == 1) ? 0 : (H % 3);
        localparam int BASE = FAN + HAN + PASS;
        localparam int PREV = (c > 0) ? (c - 1) : 0;
        localparam int CIN  = (c > 0) ?
                              (plan_query(N, QRY_FA, LVL, PREV) + plan_query(N, QRY_HA, LVL, PREV)) : 0;

        for (genvar k = 0; k < N; k++) begin : g_cnt
            if (k < FAN) begin : g_fa
                csa_full u_fa (
                    .x  (in_mat[c][3*k]),
                    .y  (in_mat[c][3*k+1]),
                    .z  (in_mat[c][3*k+2]),
                    .s  (sm[c][k]),
                    .co (cy[c][k])
                );
            end else if (k == FAN && HAN == 1) begin : g_ha
                // Half adder merging the bottom pair of the column.
                assign sm[c][k] = in_mat[c][3*FAN] ^ in_mat[c][3*FAN+1];
                assign cy[c][k] = in_mat[c][3*FAN] & in_mat[c][3*FAN+1];
            end else begin : g_none
                assign sm[c][k] = 1'b0;
                assign cy[c][k] = 1'b0;
            end
        end

        for (genvar j = 0; j < N; j++) begin : g_out
            if (j < FAN + HAN) begin : g_sum
                assign out_mat[c][j] = sm[c][j];
            end else if (j < BASE) begin : g_pass
                assign out_mat[c][j] = in_mat[c][3*FAN + j - FAN];
            end else if (j < BASE + CIN) begin : g_carry
                assign out_mat[c][j] = cy[PREV][j - BASE];
            end else begin : g_zero
                assign out_mat[c][j] = 1'b0;
            end
        end
    end

    logic unused_stage_bits;
    assign unused_stage_bits = ^{in_mat, sm, cy};

    logic [COLS-1:0] in_val;
    logic [COLS-1:0] out_val;

    // Weighted value before and after this level must agree modulo 2^(2N).
    always_comb begin
        in_val  = '0;
        out_val = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int k = 0; k < N; k++) begin
                in_val  = in_val  + (COLS'(in_mat[c][k])  << c);
                out_val = out_val + (COLS'(out_mat[c][k]) << c);
            end
        end
        // R3
        level_value_chk: assert (in_val == out_val)
            else $error("level %0d changed value %0d -> %0d", LVL, in_val, out_val);
    end

endmodule

// File: rtl/cpa_ripple.sv
`timescale 1ns/1ps
// Module: ripple carry-propagate adder that merges the last two rows. The
// carry out of the top column is dropped (the product fits in W bits).
module cpa_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] row_a,
    input  logic [W-1:0] row_b,
    output logic [W-1:0] sum_o
);

    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csa_full u_bit (
            .x  (row_a[i]),
            .y  (row_b[i]),
            .z  (carry[i]),
            .s  (sum_o[i]),
            .co (carry[i+1])
        );
    end

    logic unused_carry_out;
    assign unused_carry_out = carry[W];

    // Ripple result compared with an arithmetic add of the same rows.
    always_comb begin
        // R7
        ripple_sum_chk: assert (sum_o == W'(row_a + row_b))
            else $error("ripple sum %0d, rows %0d + %0d", sum_o, row_a, row_b);
    end

endmodule

// File: rtl/pyramid_wallace_mul.sv
`timescale 1ns/1ps
// Module: top of the unsigned N x N multiplier. Builds the packed AND matrix,
// applies the scheduled reduction levels, and adds the last two rows.
// Assumes 2 <= N <= 64. Purely combinational, no clock or reset.
module pyramid_wallace_mul #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] product_o,
    output logic [7:0]     depth_o
);

    import pyr_wallace_pkg::*;

    localparam int COLS   = 2 * N;
    localparam int LEVELS = plan_query(N, QRY_LEVELS, 0, 0);

    logic [COLS-1:0][N-1:0] mat [LEVELS+1];
    logic [COLS-1:0]        row_top;
    logic [COLS-1:0]        row_bot;

    pp_pyramid #(.N(N)) u_pp (
        .a_i   (a_i),
        .b_i   (b_i),
        .mat_o (mat[0])
    );

    for (genvar s = 0; s < LEVELS; s++) begin : g_level
        wallace_stage #(.N(N), .LVL(s)) u_stage (
            .in_mat  (mat[s]),
            .out_mat (mat[s+1])
        );
    end

    // Pick the two surviving slots of every column as the adder rows.
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            row_top[c] = mat[LEVELS][c][0];
            row_bot[c] = mat[LEVELS][c][1];
        end
    end

    logic unused_last_level;
    assign unused_last_level = ^mat[LEVELS];

    cpa_ripple #(.W(COLS)) u_cpa (
        .row_a (row_top),
        .row_b (row_bot),
        .sum_o (product_o)
    );

    assign depth_o = 8'(LEVELS);

    logic [COLS-1:0] expect_prod;

    // End-to-end product check at the block's ports.
    always_comb begin
        expect_prod = COLS'(a_i) * COLS'(b_i);
        // R1
        exact_product_chk: assert (product_o == expect_prod)
            else $error("product %0d, expected %0d", product_o, expect_prod);
        // R4
        zero_operand_chk: assert (!((a_i == '0) || (b_i == '0)) || (product_o == '0))
            else $error("zero operand gave %0d", product_o);
    end

endmodule

// File: tb/pyramid_wallace_mul_bench.sv
`timescale 1ns/1ps
// Bench: exhaustive comparison of two multiplier widths against integer
// arithmetic, plus a level-count check against the Wallace rule.
module pyramid_wallace_mul_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [7:0]  d8;
    logic [4:0]  a5, b5;
    logic [9:0]  p5;
    logic [7:0]  d5;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    pyramid_wallace_mul #(.N(8)) u_pyramid_wallace_mul (
        .a_i (a8), .b_i (b8), .product_o (p8), .depth_o (d8)
    );

    pyramid_wallace_mul #(.N(5)) u_pyramid_wallace_mul_n5 (
        .a_i (a5), .b_i (b5), .product_o (p5), .depth_o (d5)
    );

    function automatic int ref_levels(input int rows);
        int cap = 2;
        int k = 0;
        while (cap < rows) begin
            cap = (cap * 3) / 2;
            k++;
        end
        return k;
    endfunction

    task automatic check(input string req, input longint got, input longint exp,
                         input int a, input int b);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: a=%0d b=%0d got %0d expected %0d", req, a, b, got, exp);
        end
    endtask

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic string tag_of(input int a, input int b, input int maxv);
        if (a == 0 || b == 0) return "R4";
        if (a == maxv && b == maxv) return "R5";
        if (is_pow2(a) || is_pow2(b)) return "R6";
        return "R1";
    endfunction

    task automatic apply8(input int a, input int b, input string req);
        @(posedge clk);
        a8 = 8'(a);
        b8 = 8'(b);
        @(negedge clk);
        check(req, longint'(p8), longint'(a) * longint'(b), a, b);
    endtask

    task automatic apply5(input int a, input int b, input string req);
        @(posedge clk);
        a5 = 5'(a);
        b5 = 5'(b);
        @(negedge clk);
        check(req, longint'(p5), longint'(a) * longint'(b), a, b);
    endtask

    initial begin
        a8 = '0; b8 = '0; a5 = '0; b5 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: idle zero inputs give a zero product
        check("R4", longint'(p8), 0, 0, 0);
        check("R4", longint'(p5), 0, 0, 0);
        // R2: level count equals the conventional Wallace count
        check("R2", longint'(d8), longint'(ref_levels(8)), 8, 8);
        check("R2", longint'(d5), longint'(ref_levels(5)), 5, 5);
        check("R2", longint'(d8), 4, 8, 8);
        // R5: largest operands, top bit must be set
        apply8(255, 255, "R5");
        check("R5", longint'(p8[15]), 1, 255, 255);
        // R3: patterns stressing every reduction level
        apply8(8'h55, 8'hAA, "R3");
        apply8(8'hFF, 8'h81, "R3");
        apply8(8'hB7, 8'h6D, "R3");
        // R7: long carry ripple in the final adder
        apply8(8'hFF, 8'h01, "R7");
        apply8(8'h81, 8'hFF, "R7");
        apply8(8'hFE, 8'hFF, "R7");
        // R6: power-of-two operands shift the other operand
        for (int k = 0; k < 8; k++) begin
            apply8(1 << k, 8'hC3, "R6");
        end
        // R1, R4, R5, R6: exhaustive sweep at N = 8
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply8(a, b, tag_of(a, b, 255));
            end
        end
        // R8: exhaustive sweep at odd width N = 5
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                apply5(a, b, "R8");
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule